// File: doc/BRIEF.md
# Windowed Random-Access Token FIFO

This block is a single-producer, single-consumer token channel. A plain FIFO moves one word per push or pop. This channel instead lets each side work on a window of tokens before it commits. The consumer first asks whether at least N tokens are stored. It may then peek at any of those N tokens by offset from the head, in any order. It then commits a consume of N, which removes all N at once. The producer works the same way on free slots. It checks that at least M places are free, writes words by offset from the tail into those places, and commits a produce of M so that they become visible to the consumer.

Storage is one inferred RAM array with a registered read port. The depth and the word width are parameters. Both pointers wrap modulo the depth, so the depth does not have to be a power of two. A commit larger than the tokens present, or larger than the free space, is dropped. It also sets a sticky error flag, which only reset clears.

Back-pressure rules:
- Producer writes are valid/ready. `prod_wr_ready` is high only when the offset lies inside the current free space, and a word is stored only on a cycle where valid and ready are both high.
- Peeks take no back-pressure. Every peek is answered exactly one cycle later, either with data or with an error flag.

Top module: `win_token_fifo`

## Requirements
- R1: After reset the channel is empty: `cons_avail` is low for any need of 1 or more, `prod_room` is high for any need up to DEPTH, `commit_err` is low and `cons_rd_valid` is low.
- R2: `cons_avail` is high in the same cycle exactly when the stored token count is at least `cons_need`.
- R3: `prod_room` is high in the same cycle exactly when the free slot count (DEPTH minus count) is at least `prod_need`.
- R4: `prod_wr_ready` is high exactly when `prod_wr_off` is less than the free slot count. An accepted word goes to the slot at that offset past the tail. It stays invisible to the consumer until a produce commit covers it.
- R5: A peek at offset k below the count raises `cons_rd_valid` one cycle later, with `cons_rd_err` low and `cons_rd_data` equal to the k-th token from the head. Offsets may be peeked in any order.
- R6: A peek at an offset at or above the count answers one cycle later with `cons_rd_err` high and `cons_rd_data` zero. It leaves the count and the pointers unchanged.
- R7: A consume commit of n, with n no larger than the count, removes the n head tokens in one cycle: the head advances by n modulo DEPTH.
- R8: A produce commit of n, with n no larger than the free count, adds n tokens in one cycle: the tail advances by n modulo DEPTH.
- R9: When a produce commit and a consume commit are both legal in the same cycle, the count changes by their difference. Each check uses the count from before that cycle.
- R10: A commit larger than the count (consume) or larger than the free space (produce) is ignored and sets `commit_err`. The flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prod_need | input | CW | Free slots the producer asks about |
| prod_room | output | 1 | Free slots >= prod_need |
| prod_wr_valid | input | 1 | Producer write request |
| prod_wr_ready | output | 1 | Write offset lies within the free space |
| prod_wr_off | input | AW | Write offset from the tail |
| prod_wr_data | input | DATA_W | Word to write |
| prod_commit | input | 1 | Produce commit strobe |
| prod_commit_n | input | CW | Number of tokens to produce |
| cons_need | input | CW | Tokens the consumer asks about |
| cons_avail | output | 1 | Stored tokens >= cons_need |
| cons_peek_valid | input | 1 | Peek request |
| cons_peek_off | input | AW | Peek offset from the head |
| cons_rd_valid | output | 1 | Peek answer, one cycle after the request |
| cons_rd_data | output | DATA_W | Peeked word (zero on error) |
| cons_rd_err | output | 1 | Peek offset was outside the stored tokens |
| cons_commit | input | 1 | Consume commit strobe |
| cons_commit_n | input | CW | Number of tokens to consume |
| commit_err | output | 1 | Sticky flag for an ignored commit |

## Verification
The bench builds the block with DEPTH = 5 and DATA_W = 16. A depth that is not a power of two shows whether both pointers wrap by explicit comparison rather than by truncation. A depth of five also lets a few operations reach the full, the empty and the wrapped-window states. The vector table fills windows out of order, peeks them out of order and commits across the wrap point. The directed part then covers out-of-window peeks and writes, over-sized commits on both sides, and simultaneous produce and consume commits.

// File: rtl/wtf_pkg.sv
package wtf_pkg;
  // Slot index of an offset past a base pointer, wrapped modulo the depth.
  function automatic int unsigned slot_of(int unsigned base, int unsigned off,
                                          int unsigned depth);
    int unsigned s;
    s = base + off;
    if (s >= depth) s = s - depth;
    return s;
  endfunction
endpackage

// File: rtl/wtf_ptr.sv
module wtf_ptr #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [CW-1:0] adv_n,
  output logic [AW-1:0] ptr
);
  int unsigned nxt;

  always_comb nxt = wtf_pkg::slot_of(int'(ptr), int'(adv_n), DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= AW'(nxt);
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < DEPTH);  // R7
endmodule

// File: rtl/wtf_store.sv
module wtf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic              rbad,
  input  logic [AW-1:0]     raddr,
  output logic              rd_valid,
  output logic              rd_err,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= re;
      rd_err   <= re && rbad;
      if (re) rd_data <= rbad ? '0 : mem[raddr];
    end
  end

  AST_PEEK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    re |=> rd_valid);  // R5
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_err) |-> (rd_data == '0));  // R6
endmodule

// File: rtl/wtf_ctrl.sv
module wtf_ctrl #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p_commit,
  input  logic [CW-1:0] p_n,
  input  logic          c_commit,
  input  logic [CW-1:0] c_n,
  output logic [CW-1:0] count,
  output logic [CW-1:0] free,
  output logic          p_adv,
  output logic          c_adv,
  output logic          err
);
  logic p_bad, c_bad;

  always_comb begin
    free  = CW'(DEPTH) - count;
    p_adv = p_commit && (p_n <= free);
    c_adv = c_commit && (c_n <= count);
    p_bad = p_commit && !p_adv;
    c_bad = c_commit && !c_adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      err   <= 1'b0;
    end else begin
      count <= count + (p_adv ? p_n : '0) - (c_adv ? c_n : '0);
      if (p_bad || c_bad) err <= 1'b1;
    end
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);  // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);  // R10
  AST_BAD_CONSUME_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (c_commit && (c_n > count)) |=> err);  // R10
  AST_BAD_CONSUME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_commit && (c_n > count) && !p_commit) |=> $stable(count));  // R10
  AST_BAD_PRODUCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (p_commit && (p_n > free) && !c_commit) |=> $stable(count));  // R10
endmodule

// File: rtl/win_token_fifo.sv
module win_token_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     prod_need,
  output logic              prod_room,
  input  logic              prod_wr_valid,
  output logic              prod_wr_ready,
  input  logic [AW-1:0]     prod_wr_off,
  input  logic [DATA_W-1:0] prod_wr_data,
  input  logic              prod_commit,
  input  logic [CW-1:0]     prod_commit_n,
  input  logic [CW-1:0]     cons_need,
  output logic              cons_avail,
  input  logic              cons_peek_valid,
  input  logic [AW-1:0]     cons_peek_off,
  output logic              cons_rd_valid,
  output logic [DATA_W-1:0] cons_rd_data,
  output logic              cons_rd_err,
  input  logic              cons_commit,
  input  logic [CW-1:0]     cons_commit_n,
  output logic              commit_err
);
  logic [CW-1:0] count, free;
  logic          p_adv, c_adv;
  logic [AW-1:0] head, tail, waddr, raddr;
  logic          peek_bad;

  wtf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .p_commit(prod_commit), .p_n(prod_commit_n),
    .c_commit(cons_commit), .c_n(cons_commit_n),
    .count(count), .free(free), .p_adv(p_adv), .c_adv(c_adv), .err(commit_err)
  );

  wtf_ptr #(.DEPTH(DEPTH)) u_head (
    .clk(clk), .rst_n(rst_n), .adv(c_adv), .adv_n(cons_commit_n), .ptr(head)
  );

  wtf_ptr #(.DEPTH(DEPTH)) u_tail (
    .clk(clk), .rst_n(rst_n), .adv(p_adv), .adv_n(prod_commit_n), .ptr(tail)
  );

  always_comb begin
    prod_room     = free >= prod_need;
    cons_avail    = count >= cons_need;
    prod_wr_ready = CW'(prod_wr_off) < free;
    peek_bad      = CW'(cons_peek_off) >= count;
    waddr = AW'(wtf_pkg::slot_of(int'(tail), int'(prod_wr_off), DEPTH));
    raddr = AW'(wtf_pkg::slot_of(int'(head), int'(cons_peek_off), DEPTH));
  end

  wtf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(prod_wr_valid && prod_wr_ready), .waddr(waddr), .wdata(prod_wr_data),
    .re(cons_peek_valid), .rbad(peek_bad), .raddr(raddr),
    .rd_valid(cons_rd_valid), .rd_err(cons_rd_err), .rd_data(cons_rd_data)
  );

  AST_PEEK_NO_SIDE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_peek_valid && !prod_commit && !cons_commit) |=> $stable(count));  // R6
  AST_EMPTY_NO_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && cons_need != '0) |-> !cons_avail);  // R2
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) == DEPTH) |-> !prod_wr_ready);  // R4
endmodule

// File: tb/test_win_token_fifo.sv
module test_win_token_fifo;
  localparam int DW = 16;
  localparam int DEPTH = 5;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  localparam logic [2:0] OP_WR = 3'd0, OP_PC = 3'd1, OP_CC = 3'd2,
                         OP_PK = 3'd3, OP_PE = 3'd4, OP_AV = 3'd5, OP_RM = 3'd6;

  typedef struct packed {
    logic [2:0]    op;
    logic [3:0]    n;
    logic [DW-1:0] data;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{OP_WR, 4'd1, 16'h00B1}, '{OP_WR, 4'd0, 16'h00A0}, '{OP_WR, 4'd2, 16'h00C2},
    '{OP_AV, 4'd1, 16'd0},    '{OP_PC, 4'd3, 16'd0},
    '{OP_AV, 4'd3, 16'd1},    '{OP_AV, 4'd4, 16'd0},
    '{OP_RM, 4'd2, 16'd1},    '{OP_RM, 4'd3, 16'd0},
    '{OP_PK, 4'd2, 16'h00C2}, '{OP_PK, 4'd0, 16'h00A0}, '{OP_PK, 4'd1, 16'h00B1},
    '{OP_PE, 4'd3, 16'd0},
    '{OP_CC, 4'd2, 16'd0},    '{OP_PK, 4'd0, 16'h00C2},
    '{OP_WR, 4'd0, 16'h00D3}, '{OP_WR, 4'd3, 16'h00E6}, '{OP_WR, 4'd1, 16'h00E4},
    '{OP_WR, 4'd2, 16'h00F5}, '{OP_PC, 4'd4, 16'd0},
    '{OP_RM, 4'd1, 16'd0},    '{OP_AV, 4'd5, 16'd1},
    '{OP_PK, 4'd4, 16'h00E6}, '{OP_PK, 4'd1, 16'h00D3},
    '{OP_CC, 4'd3, 16'd0},    '{OP_PK, 4'd0, 16'h00F5}, '{OP_PK, 4'd1, 16'h00E6}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] prod_need = '0, cons_need = '0;
  logic [CW-1:0] prod_commit_n = '0, cons_commit_n = '0;
  logic          prod_wr_valid = 1'b0, prod_commit = 1'b0;
  logic          cons_peek_valid = 1'b0, cons_commit = 1'b0;
  logic [AW-1:0] prod_wr_off = '0, cons_peek_off = '0;
  logic [DW-1:0] prod_wr_data = '0;
  logic          prod_room, prod_wr_ready, cons_avail;
  logic          cons_rd_valid, cons_rd_err, commit_err;
  logic [DW-1:0] cons_rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  win_token_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_win_token_fifo (
    .clk(clk), .rst_n(rst_n),
    .prod_need(prod_need), .prod_room(prod_room),
    .prod_wr_valid(prod_wr_valid), .prod_wr_ready(prod_wr_ready),
    .prod_wr_off(prod_wr_off), .prod_wr_data(prod_wr_data),
    .prod_commit(prod_commit), .prod_commit_n(prod_commit_n),
    .cons_need(cons_need), .cons_avail(cons_avail),
    .cons_peek_valid(cons_peek_valid), .cons_peek_off(cons_peek_off),
    .cons_rd_valid(cons_rd_valid), .cons_rd_data(cons_rd_data),
    .cons_rd_err(cons_rd_err),
    .cons_commit(cons_commit), .cons_commit_n(cons_commit_n),
    .commit_err(commit_err)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic avail(int n, logic exp, string req);
    cons_need = CW'(n);
    #1 check(req, 32'(cons_avail), 32'(exp));
  endtask

  task automatic room(int n, logic exp, string req);
    prod_need = CW'(n);
    #1 check(req, 32'(prod_room), 32'(exp));
  endtask

  task automatic write(int off, logic [DW-1:0] d);
    @(negedge clk);
    prod_wr_valid = 1'b1; prod_wr_off = AW'(off); prod_wr_data = d;
    #1 check("R4 write ready", 32'(prod_wr_ready), 32'd1);
    @(negedge clk);
    prod_wr_valid = 1'b0;
  endtask

  task automatic commit(logic p, int pn, logic c, int cn);
    @(negedge clk);
    prod_commit = p; prod_commit_n = CW'(pn);
    cons_commit = c; cons_commit_n = CW'(cn);
    @(negedge clk);
    prod_commit = 1'b0; cons_commit = 1'b0;
  endtask

  task automatic peek(int off, logic exp_err, logic [DW-1:0] exp_d, string req);
    @(negedge clk);
    cons_peek_valid = 1'b1; cons_peek_off = AW'(off);
    @(negedge clk);
    cons_peek_valid = 1'b0;
    check(req, 32'(cons_rd_valid), 32'd1);
    check(req, 32'(cons_rd_err), 32'(exp_err));
    check(req, 32'(cons_rd_data), 32'(exp_d));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    avail(1, 1'b0, "R1 empty after reset");
    room(DEPTH, 1'b1, "R1 all room after reset");
    check("R1 err clear", 32'(commit_err), 32'd0);
    check("R1 no read", 32'(cons_rd_valid), 32'd0);

    // table: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        OP_WR: write(int'(TBL[i].n), TBL[i].data);
        OP_PC: commit(1'b1, int'(TBL[i].n), 1'b0, 0);
        OP_CC: commit(1'b0, 0, 1'b1, int'(TBL[i].n));
        OP_PK: peek(int'(TBL[i].n), 1'b0, TBL[i].data, "R5 peek by offset");
        OP_PE: peek(int'(TBL[i].n), 1'b1, '0, "R6 peek past count");
        OP_AV: avail(int'(TBL[i].n), TBL[i].data[0], "R2 avail predicate");
        OP_RM: room(int'(TBL[i].n), TBL[i].data[0], "R3 room predicate");
        default: ;
      endcase
    end
    check("R10 no error yet", 32'(commit_err), 32'd0);

    // now: 2 tokens (F5, E6), free 3
    @(negedge clk);
    prod_wr_off = AW'(3);
    #1 check("R4 ready low past free", 32'(prod_wr_ready), 32'd0);
    prod_wr_off = AW'(2);
    #1 check("R4 ready high inside free", 32'(prod_wr_ready), 32'd1);

    peek(2, 1'b1, '0, "R6 peek at count");
    avail(2, 1'b1, "R6 count unchanged");
    avail(3, 1'b0, "R6 count unchanged");

    commit(1'b0, 0, 1'b1, 3);
    check("R10 over consume flagged", 32'(commit_err), 32'd1);
    avail(2, 1'b1, "R10 over consume ignored");
    avail(3, 1'b0, "R10 over consume ignored");
    peek(0, 1'b0, 16'h00F5, "R10 head unchanged");

    write(0, 16'h0077);
    avail(3, 1'b0, "R4 uncommitted write invisible");
    commit(1'b1, 1, 1'b1, 1);
    avail(2, 1'b1, "R9 net zero change");
    avail(3, 1'b0, "R9 net zero change");
    peek(0, 1'b0, 16'h00E6, "R7 head advanced");
    peek(1, 1'b0, 16'h0077, "R8 produced token visible");

    commit(1'b1, 4, 1'b0, 0);
    room(3, 1'b1, "R10 over produce ignored");
    avail(3, 1'b0, "R10 over produce ignored");
    check("R10 err sticky", 32'(commit_err), 32'd1);

    commit(1'b1, 3, 1'b1, 2);
    avail(3, 1'b1, "R9 net plus one");
    avail(4, 1'b0, "R9 net plus one");

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 err cleared by reset", 32'(commit_err), 32'd0);
    avail(1, 1'b0, "R1 empty after second reset");
    finish_run();
  end
endmodule